// File: doc/BRIEF.md
# Reverse-Current Fault Recovery Sequencer

This block decides when the two series pass devices of a protected power switch may conduct after current has been seen flowing backwards from the output to the input. One device is the internal pass transistor and the other is an optional external blocking transistor. Two comparators report reverse voltage across the switch. A shallow threshold must persist for a filter window before it counts. A deep threshold acts at once. When either trips, both devices are turned off and a recovery interval begins. The reverse condition is watched for the whole of that interval.

When the recovery interval ends with the condition gone, each device is given back its turn-on permission after its own delay. The internal device always comes back first. Both delays grow by a debounce amount if the output voltage had sagged below its undervoltage level when recovery ended. At the moment the internal device is released, a one-cycle restart request tells the startup controller to run its staged inrush sequence again. This happens whatever current-limit mode is selected. All timing is counted in ticks of an external timebase strobe, so the same logic serves any clock rate.

Top module: `rev_recovery_seq`

## Requirements
- R1: After reset both turn-on outputs are 1, the fault flag is 0 and the restart request is 0.
- R2: While the protection enable is 0, neither comparator input has any effect: both devices stay on and the fault flag stays 0.
- R3: A deep-threshold input that is 1 at a clock edge turns both devices off and raises the fault flag at the following edge, which is two edges after the input is applied.
- R4: A shallow-threshold input trips only after it has been 1 for SLOW_TICKS consecutive ticks. The trip then shows SLOW_TICKS+1 edges after the input is applied. A pulse held for SLOW_TICKS-1 cycles causes no trip.
- R5: Once tripped, both devices stay off and the flag stays 1 for REC_TICKS ticks.
- R6: If either comparator is still reporting reverse current when a recovery interval ends, a new full recovery interval starts and both devices stay off.
- R7: If the output-above-undervoltage input was 1 at the end of recovery, the internal device turns on INT_DLY_TICKS ticks later and the external device EXT_DLY_TICKS ticks later.
- R8: If that input was 0 at the end of recovery, both delays are extended by DEB_TICKS.
- R9: The output-voltage input is sampled only at the end of recovery. Changes to it before or after that point do not alter the delays.
- R10: The restart request is a single-cycle pulse. It occurs exactly in the cycle where the internal device turns back on, and once per recovery.
- R11: The external device is never on while the internal one is off. The fault flag is 1 exactly while either device is held off by the sequencer.
- R12: A new trip during the turn-on delays turns the devices off again and starts a fresh recovery interval.
- R13: Every interval counts only cycles in which the tick input is 1. Cycles without a tick extend the interval by that many cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase strobe; one timer unit per cycle in which it is 1 |
| rp_en_i | input | 1 | Reverse-protection enable; 1 activates the feature |
| slow_rev_i | input | 1 | Shallow reverse-threshold comparator, 1 = reverse detected |
| fast_rev_i | input | 1 | Deep reverse-threshold comparator, 1 = reverse detected |
| out_ok_i | input | 1 | 1 when the output is at or above its undervoltage level |
| int_on_o | output | 1 | Turn-on permission for the internal pass device |
| ext_on_o | output | 1 | Turn-on permission for the external blocking device |
| rev_fault_o | output | 1 | Reverse-current fault flag |
| restart_o | output | 1 | One-cycle restart request to the startup controller |

## Verification
The bench builds the block with SLOW_TICKS=6, REC_TICKS=20, INT_DLY_TICKS=8, EXT_DLY_TICKS=30 and DEB_TICKS=12, with the tick strobe high in most cycles. These values shrink every interval to tens of cycles. That allows repeated recoveries, both delay sets, re-trips that land inside the gap between the two delays, and filter pulses one tick short of the threshold, all within a short run. With the internal delay well below the external one, a window remains open in which a single device is on. The pauses in the tick strobe then show, cycle for cycle, that the counters freeze.

// File: rtl/rev_recovery_pkg.sv
package rev_recovery_pkg;

  typedef enum logic [1:0] {
    RR_RUN   = 2'd0,
    RR_HOLD  = 2'd1,
    RR_DELAY = 2'd2
  } rr_state_e;

  // counter width able to hold values 0..maxv
  function automatic int unsigned rr_width(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  // turn-on delay of one device after recovery
  function automatic int unsigned rr_on_delay(input int unsigned base,
                                              input int unsigned deb,
                                              input logic out_low);
    return out_low ? (base + deb) : base;
  endfunction

  function automatic int unsigned rr_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rev_trip_filter.sv
module rev_trip_filter
  import rev_recovery_pkg::*;
#(
  parameter int unsigned SLOW_TICKS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic en_i,
  input  logic slow_i,
  input  logic fast_i,
  output logic trip_o,
  output logic present_o
);
  localparam int unsigned SW = rr_width(SLOW_TICKS);
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_TICKS - 1);

  logic          slow_q, fast_q;
  logic [SW-1:0] scnt_q;
  logic          slow_trip;

  // one sampling register per comparator, gated by the enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= 1'b0;
      fast_q <= 1'b0;
      scnt_q <= '0;
    end else begin
      slow_q <= slow_i & en_i;
      fast_q <= fast_i & en_i;
      if (!slow_q)
        scnt_q <= '0;
      else if (tick_i && scnt_q != SLOW_LAST)
        scnt_q <= scnt_q + 1'b1;
    end
  end

  assign slow_trip = slow_q && tick_i && (scnt_q == SLOW_LAST);
  assign trip_o    = slow_trip | fast_q;
  assign present_o = slow_q | fast_q;

endmodule

// File: rtl/rev_tick_timer.sv
module rev_tick_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_o <= '0;
    else if (clr_i)
      cnt_o <= '0;
    else if (tick_i && cnt_o != {W{1'b1}})
      cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rev_recovery_seq.sv
module rev_recovery_seq
  import rev_recovery_pkg::*;
#(
  parameter int unsigned SLOW_TICKS    = 30,
  parameter int unsigned REC_TICKS     = 450,
  parameter int unsigned INT_DLY_TICKS = 200,
  parameter int unsigned EXT_DLY_TICKS = 1200,
  parameter int unsigned DEB_TICKS     = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rp_en_i,
  input  logic slow_rev_i,
  input  logic fast_rev_i,
  input  logic out_ok_i,
  output logic int_on_o,
  output logic ext_on_o,
  output logic rev_fault_o,
  output logic restart_o
);
  localparam int unsigned MAXC = rr_max(REC_TICKS, EXT_DLY_TICKS + DEB_TICKS);
  localparam int unsigned CW   = rr_width(MAXC);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_TICKS - 1);

  rr_state_e     state_q, state_nx;
  logic          low_q;
  logic          ok_q;
  logic          restart_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] ndly, pdly;

  // named internal events
  logic trip_now;
  logic rev_present;
  logic rec_done;
  logic int_hit;
  logic dly_done;
  logic cnt_clr;

  rev_trip_filter #(.SLOW_TICKS(SLOW_TICKS)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .en_i     (rp_en_i),
    .slow_i   (slow_rev_i),
    .fast_i   (fast_rev_i),
    .trip_o   (trip_now),
    .present_o(rev_present)
  );

  rev_tick_timer #(.W(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .tick_i(tick_i),
    .cnt_o (cnt)
  );

  assign ndly = CW'(rr_on_delay(INT_DLY_TICKS, DEB_TICKS, low_q));
  assign pdly = CW'(rr_on_delay(EXT_DLY_TICKS, DEB_TICKS, low_q));

  assign rec_done = (state_q == RR_HOLD)  && tick_i && (cnt == REC_LAST);
  assign int_hit  = (state_q == RR_DELAY) && tick_i && (cnt == ndly - 1'b1);
  assign dly_done = (state_q == RR_DELAY) && tick_i && (cnt == pdly - 1'b1);

  always_comb begin
    state_nx = state_q;
    case (state_q)
      RR_RUN:   if (trip_now) state_nx = RR_HOLD;
      RR_HOLD:  if (rec_done && !rev_present) state_nx = RR_DELAY;
      RR_DELAY: begin
        if (trip_now)      state_nx = RR_HOLD;
        else if (dly_done) state_nx = RR_RUN;
      end
      default:  state_nx = RR_RUN;
    endcase
  end

  assign cnt_clr = (state_nx != state_q) || rec_done || (state_q == RR_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RR_RUN;
      low_q     <= 1'b0;
      ok_q      <= 1'b1;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_nx;
      ok_q      <= out_ok_i;
      restart_q <= int_hit && !trip_now;
      if (rec_done && !rev_present)
        low_q <= !ok_q;
    end
  end

  assign int_on_o    = (state_q == RR_RUN) || ((state_q == RR_DELAY) && (cnt >= ndly));
  assign ext_on_o    = (state_q == RR_RUN);
  assign rev_fault_o = (state_q != RR_RUN);
  assign restart_o   = restart_q;

endmodule

// File: rtl/rev_recovery_chk.sv
module rev_recovery_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic trip_now,
  input logic int_on_o,
  input logic ext_on_o,
  input logic rev_fault_o,
  input logic restart_o
);
  assert_ext_needs_int_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_on_o |-> int_on_o);

  assert_flag_matches_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rev_fault_o |-> (int_on_o && ext_on_o));

  assert_trip_turns_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trip_now |=> (!int_on_o && !ext_on_o && rev_fault_o));

  assert_restart_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> (int_on_o && !$past(int_on_o)));

  assert_restart_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);

  assert_frozen_without_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !trip_now) |=> ($stable(int_on_o) && $stable(ext_on_o)));
endmodule

bind rev_recovery_seq rev_recovery_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .trip_now   (trip_now),
  .int_on_o   (int_on_o),
  .ext_on_o   (ext_on_o),
  .rev_fault_o(rev_fault_o),
  .restart_o  (restart_o)
);

// File: tb/tb_rev_recovery_seq.sv
`timescale 1ns/1ps
module tb_rev_recovery_seq;
  localparam int SLOW = 6;
  localparam int REC  = 20;
  localparam int NUP  = 8;
  localparam int PUP  = 30;
  localparam int DEB  = 12;
  localparam int NONE = 9999;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic rp_en = 1'b1;
  logic slow_rev = 1'b0;
  logic fast_rev = 1'b0;
  logic out_ok = 1'b1;
  logic int_on, ext_on, rev_fault, restart;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  rev_recovery_seq #(
    .SLOW_TICKS(SLOW), .REC_TICKS(REC), .INT_DLY_TICKS(NUP),
    .EXT_DLY_TICKS(PUP), .DEB_TICKS(DEB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .rp_en_i(rp_en),
    .slow_rev_i(slow_rev), .fast_rev_i(fast_rev), .out_ok_i(out_ok),
    .int_on_o(int_on), .ext_on_o(ext_on), .rev_fault_o(rev_fault), .restart_o(restart)
  );

  task automatic chk(input bit good, input string req, input int act, input int exp);
    nchk++;
    if (!good) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // fields: kind(1=fast), ok0, hold, sw_cyc, ok1, exp_low, frz_at, frz_len
  localparam int VEC [8][8] = '{
    '{1, 1, 0,       NONE,    1, 0, NONE, 0 },  // R3 R5 R7
    '{0, 1, 0,       NONE,    1, 0, NONE, 0 },  // R4 R7
    '{1, 0, 0,       NONE,    0, 1, NONE, 0 },  // R8
    '{0, 0, REC+5,   NONE,    0, 1, NONE, 0 },  // R6 R8
    '{1, 1, 0,       3,       0, 1, NONE, 0 },  // R9 change before end
    '{1, 0, 0,       REC+2,   1, 1, NONE, 0 },  // R9 change after end
    '{1, 1, 0,       NONE,    1, 0, 5,    15},  // R13
    '{1, 1, 2*REC+3, NONE,    1, 0, NONE, 0 }   // R6 two repeats
  };

  task automatic drop_inputs();
    fast_rev = 1'b0;
    slow_rev = 1'b0;
  endtask

  task automatic run_vec(input int i);
    int kind, ok0, hold, sw, ok1, explow, frz_at, frz_len;
    int lat, recs, exp_i, exp_e, cyc, int_at, ext_at, rs_at, rs_n;
    kind = VEC[i][0]; ok0 = VEC[i][1]; hold = VEC[i][2]; sw = VEC[i][3];
    ok1 = VEC[i][4]; explow = VEC[i][5]; frz_at = VEC[i][6]; frz_len = VEC[i][7];
    recs  = (hold + 1) / REC + 1;
    exp_i = recs * REC + NUP + (explow ? DEB : 0) + frz_len;
    exp_e = recs * REC + PUP + (explow ? DEB : 0) + frz_len;
    out_ok = ok0[0];
    @(negedge clk);
    if (kind == 1) fast_rev = 1'b1; else slow_rev = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!rev_fault && lat < 200);
    chk(lat == ((kind == 1) ? 2 : SLOW + 1), (kind == 1) ? "R3 trip latency" : "R4 trip latency",
        lat, (kind == 1) ? 2 : SLOW + 1);
    chk(!int_on && !ext_on, "R5 both off at trip", {int_on, ext_on}, 0);
    if (hold == 0) drop_inputs();
    cyc = 0; int_at = -1; ext_at = -1; rs_at = -1; rs_n = 0;
    while (ext_at < 0 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (restart) begin rs_n++; rs_at = cyc; end
      if (int_on && int_at < 0) int_at = cyc;
      if (ext_on) ext_at = cyc;
      if (cyc == hold) drop_inputs();
      if (cyc == sw) out_ok = ok1[0];
      if (cyc == frz_at) tick_en = 1'b0;
      if (cyc == frz_at + frz_len) tick_en = 1'b1;
    end
    chk(int_at == exp_i, explow ? "R8 internal delay" : "R7 internal delay", int_at, exp_i);
    chk(ext_at == exp_e, explow ? "R8 external delay" : "R7 external delay", ext_at, exp_e);
    chk(rs_at == int_at && rs_n == 1, "R10 restart pulse", rs_at * 10 + rs_n, int_at * 10 + 1);
    chk(!rev_fault, "R11 flag clear with both on", rev_fault, 0);
    tick_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int bad, cyc;
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held
    chk(int_on && ext_on && !rev_fault && !restart, "R1 reset outputs",
        {int_on, ext_on, rev_fault, restart}, 4'b1100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(int_on && ext_on && !rev_fault && !restart, "R1 after release",
        {int_on, ext_on, rev_fault, restart}, 4'b1100);

    for (int i = 0; i < 8; i++) run_vec(i);

    // R2 enable low: comparators ignored
    rp_en = 1'b0; fast_rev = 1'b1; slow_rev = 1'b1;
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (rev_fault || !int_on || !ext_on) bad++;
    end
    chk(bad == 0, "R2 disabled protection", bad, 0);
    drop_inputs();
    repeat (2) @(negedge clk);
    rp_en = 1'b1;
    repeat (2) @(negedge clk);

    // R4 pulse one tick short of the filter window
    slow_rev = 1'b1;
    repeat (SLOW - 1) @(negedge clk);
    slow_rev = 1'b0;
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (rev_fault || !int_on) bad++;
    end
    chk(bad == 0, "R4 short pulse ignored", bad, 0);

    // R12 re-trip between the two turn-on delays
    out_ok = 1'b1;
    fast_rev = 1'b1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!rev_fault && cyc < 50);
    fast_rev = 1'b0;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!int_on && cyc < 200);
    chk(int_on && !ext_on, "R11 internal first", {int_on, ext_on}, 2'b10);
    fast_rev = 1'b1;
    repeat (2) @(negedge clk);
    chk(!int_on && !ext_on && rev_fault, "R12 re-trip off",
        {int_on, ext_on, rev_fault}, 3'b001);
    fast_rev = 1'b0;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!ext_on && cyc < 500);
    chk(cyc == REC + PUP, "R12 fresh recovery", cyc, REC + PUP);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule